// File: doc/BRIEF.md
# Store Buffer with Read Lookup

This block holds stores on their way from a write-through cache to slow main memory. The processor hands each store (address and data) to the buffer over a valid/ready handshake. The buffer then sends the stored entries to memory one at a time, oldest first, over a second valid/ready handshake. Because of this, a run of back-to-back stores does not stall on memory latency.

The buffer may hold the only current copy of a location. For that reason, every memory read passes through the buffer's read port before memory is touched. The read controller has three states:

- `RD_IDLE`: waits for a request.
- `RD_WAIT`: the drain-first mode is holding the read until the buffer is empty.
- `RD_RESP`: a one-cycle answer.

The transitions are:

- `RD_IDLE -> RD_RESP` on a request in lookup mode, or on a request in drain-first mode when the buffer is already empty.
- `RD_IDLE -> RD_WAIT` on a request in drain-first mode when the buffer still holds entries.
- `RD_WAIT -> RD_RESP` once the buffer is empty.
- `RD_RESP -> RD_IDLE` always.

In lookup mode, every live entry is compared with the read address in parallel. On a match, the newest matching data is returned and memory is not read. On no match, the memory read is released. In drain-first mode, the read is released to memory only after the buffer has emptied, and data is never taken from the buffer.

Top module: `write_buffer`

## Requirements
- R1: After reset the buffer is empty: `empty`=1, `full`=0, `mem_wr_valid`=0, `push_ready`=1, and `rd_ack`=0.
- R2: Entries go to memory in the order they were accepted. The oldest entry is presented on `mem_wr_addr`/`mem_wr_data` while `mem_wr_valid`=1, and it stays unchanged until a cycle with `mem_wr_ready`=1 removes it.
- R3: With 4 entries held, `full`=1 and `push_ready`=0. A store offered while full is not accepted and does not change the buffer's contents.
- R4: An accepted store and a drain in the same cycle both take effect.
- R5: In lookup mode (`fwd_mode`=1), a request sampled at clock edge N in `RD_IDLE` gives `rd_ack`=1 for the cycle after edge N. When a live entry holds the address, that cycle also shows `rd_hit`=1, the entry's data on `rd_data`, and `mem_rd_go`=0.
- R6: When several live entries hold the read address, `rd_data` returns the data of the most recently accepted one.
- R7: In lookup mode, when no live entry matches, the answer cycle shows `rd_hit`=0 and `mem_rd_go`=1.
- R8: In drain-first mode (`fwd_mode`=0), a request made while entries remain gets no answer until the buffer is empty. `rd_ack` rises in the cycle after the first edge at which the buffer is seen empty, with `rd_hit`=0 and `mem_rd_go`=1, even if a drained entry held the same address.
- R9: While a drain-first read is waiting, `push_ready`=0, so the buffer can only shrink.
- R10: `rd_ack` lasts exactly one cycle, and `rd_hit` and `mem_rd_go` are high only together with `rd_ack`.
- R11: Entries that have already been drained take no part in the lookup.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| fwd_mode | input | 1 | 1 = lookup mode, 0 = drain-first mode |
| push_valid | input | 1 | Store offered by the processor |
| push_ready | output | 1 | Buffer accepts the offered store |
| push_addr | input | AW | Store address |
| push_data | input | DW | Store data |
| mem_wr_valid | output | 1 | Oldest entry is offered to memory |
| mem_wr_ready | input | 1 | Memory takes the offered entry |
| mem_wr_addr | output | AW | Address of oldest entry |
| mem_wr_data | output | DW | Data of oldest entry |
| rd_req | input | 1 | Read request, held until acknowledged |
| rd_addr | input | AW | Read address |
| rd_ack | output | 1 | One-cycle read answer |
| rd_hit | output | 1 | Answer comes from the buffer |
| rd_data | output | DW | Forwarded data |
| mem_rd_go | output | 1 | Memory read may proceed |
| full | output | 1 | All entries used |
| empty | output | 1 | No entries held |

## Verification
The hardest situation to reach is a lookup in which several live entries share the read address while the buffer sits at its full limit. Reaching it needs the drain side held off while stores accumulate, and the buffer must also have wrapped its pointers. The bench gets there by first pushing and draining a few entries so that the head has moved, then holding `mem_wr_ready` low while it stores two values to one address among four entries. It then walks a table of read addresses against that frozen content, and only afterwards drains the buffer to confirm the order. Drain-first waiting is reached by releasing memory one entry per cycle after the request, so the answer cycle can be counted exactly.

// File: rtl/wb_pkg.sv
package wb_pkg;
    typedef enum logic [1:0] {
        RD_IDLE = 2'd0,
        RD_WAIT = 2'd1,
        RD_RESP = 2'd2
    } rd_state_t;
endpackage

// File: rtl/wb_store.sv
// Circular entry storage; DEPTH must be a power of two.
module wb_store #(
    parameter int DEPTH = 4,
    parameter int AW    = 32,
    parameter int DW    = 32
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      push_en,
    input  logic [AW-1:0]             in_addr,
    input  logic [DW-1:0]             in_data,
    input  logic                      pop_en,
    output logic [AW-1:0]             head_addr,
    output logic [DW-1:0]             head_data,
    output logic                      is_full,
    output logic                      is_empty,
    output logic [DEPTH-1:0]          age_valid,
    output logic [DEPTH-1:0][AW-1:0]  age_addr,
    output logic [DEPTH-1:0][DW-1:0]  age_data
);
    localparam int PW = $clog2(DEPTH);
    localparam int CW = $clog2(DEPTH + 1);

    logic [AW-1:0] addr_q [DEPTH];
    logic [DW-1:0] data_q [DEPTH];
    logic [PW-1:0] wr_ptr, rd_ptr;
    logic [CW-1:0] count;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            count  <= '0;
        end else begin
            if (push_en) begin
                addr_q[wr_ptr] <= in_addr;
                data_q[wr_ptr] <= in_data;
                wr_ptr         <= wr_ptr + PW'(1);
            end
            if (pop_en) rd_ptr <= rd_ptr + PW'(1);
            case ({push_en, pop_en})
                2'b10:   count <= count + CW'(1);
                2'b01:   count <= count - CW'(1);
                default: count <= count;
            endcase
        end
    end

    assign is_full   = (count == CW'(DEPTH));
    assign is_empty  = (count == '0);
    assign head_addr = addr_q[rd_ptr];
    assign head_data = data_q[rd_ptr];

    // Age-ordered view: position 0 is the oldest live entry.
    for (genvar g = 0; g < DEPTH; g++) begin : g_age
        logic [PW-1:0] slot;
        assign slot         = rd_ptr + PW'(g);
        assign age_valid[g] = (CW'(g) < count);
        assign age_addr[g]  = addr_q[slot];
        assign age_data[g]  = data_q[slot];
    end
endmodule

// File: rtl/wb_match.sv
// Parallel address compare; the youngest matching entry wins.
module wb_match #(
    parameter int DEPTH = 4,
    parameter int AW    = 32,
    parameter int DW    = 32
) (
    input  logic                      [DEPTH-1:0] age_valid,
    input  logic [DEPTH-1:0][AW-1:0]  age_addr,
    input  logic [DEPTH-1:0][DW-1:0]  age_data,
    input  logic [AW-1:0]             look_addr,
    output logic                      look_hit,
    output logic [DW-1:0]             look_data
);
    logic [DEPTH-1:0] eq;

    for (genvar g = 0; g < DEPTH; g++) begin : g_cmp
        assign eq[g] = age_valid[g] && (age_addr[g] == look_addr);
    end

    always_comb begin
        look_hit  = 1'b0;
        look_data = '0;
        for (int k = 0; k < DEPTH; k++) begin
            if (eq[k]) begin
                look_hit  = 1'b1;
                look_data = age_data[k];
            end
        end
    end
endmodule

// File: rtl/wb_rdctl.sv
module wb_rdctl
    import wb_pkg::*;
#(
    parameter int DW = 32
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          fwd_mode,
    input  logic          rd_req,
    input  logic          buf_empty,
    input  logic          look_hit,
    input  logic [DW-1:0] look_data,
    output logic          rd_ack,
    output logic          rd_hit,
    output logic [DW-1:0] rd_data,
    output logic          mem_rd_go,
    output logic          hold_push
);
    rd_state_t state, nxt;
    logic          cap_hit;
    logic [DW-1:0] cap_data;

    always_ff @(posedge clk) begin
        if (!rst_n) state <= RD_IDLE;
        else        state <= nxt;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cap_hit  <= 1'b0;
            cap_data <= '0;
        end else if (state == RD_IDLE && rd_req) begin
            cap_hit  <= fwd_mode && look_hit;
            cap_data <= look_data;
        end else if (state == RD_WAIT) begin
            cap_hit  <= 1'b0;
        end
    end

    always_comb begin
        nxt = state;
        unique case (state)
            RD_IDLE: if (rd_req) nxt = (fwd_mode || buf_empty) ? RD_RESP : RD_WAIT;
            RD_WAIT: if (buf_empty) nxt = RD_RESP;
            RD_RESP: nxt = RD_IDLE;
            default: nxt = RD_IDLE;
        endcase
    end

    always_comb begin
        rd_ack    = 1'b0;
        rd_hit    = 1'b0;
        rd_data   = '0;
        mem_rd_go = 1'b0;
        hold_push = 1'b0;
        unique case (state)
            RD_IDLE: ;
            RD_WAIT: hold_push = 1'b1;
            RD_RESP: begin
                rd_ack    = 1'b1;
                rd_hit    = cap_hit;
                rd_data   = cap_hit ? cap_data : '0;
                mem_rd_go = !cap_hit;
            end
            default: ;
        endcase
    end
endmodule

// File: rtl/write_buffer.sv
module write_buffer #(
    parameter int DEPTH = 4,
    parameter int AW    = 32,
    parameter int DW    = 32
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          fwd_mode,
    input  logic          push_valid,
    output logic          push_ready,
    input  logic [AW-1:0] push_addr,
    input  logic [DW-1:0] push_data,
    output logic          mem_wr_valid,
    input  logic          mem_wr_ready,
    output logic [AW-1:0] mem_wr_addr,
    output logic [DW-1:0] mem_wr_data,
    input  logic          rd_req,
    input  logic [AW-1:0] rd_addr,
    output logic          rd_ack,
    output logic          rd_hit,
    output logic [DW-1:0] rd_data,
    output logic          mem_rd_go,
    output logic          full,
    output logic          empty
);
    logic                     hold_push, look_hit;
    logic [DW-1:0]            look_data;
    logic [DEPTH-1:0]         age_valid;
    logic [DEPTH-1:0][AW-1:0] age_addr;
    logic [DEPTH-1:0][DW-1:0] age_data;

    assign push_ready   = !full && !hold_push;
    assign mem_wr_valid = !empty;

    wb_store #(.DEPTH(DEPTH), .AW(AW), .DW(DW)) u_store (
        .clk       (clk),
        .rst_n     (rst_n),
        .push_en   (push_valid && push_ready),
        .in_addr   (push_addr),
        .in_data   (push_data),
        .pop_en    (mem_wr_valid && mem_wr_ready),
        .head_addr (mem_wr_addr),
        .head_data (mem_wr_data),
        .is_full   (full),
        .is_empty  (empty),
        .age_valid (age_valid),
        .age_addr  (age_addr),
        .age_data  (age_data)
    );

    wb_match #(.DEPTH(DEPTH), .AW(AW), .DW(DW)) u_match (
        .age_valid (age_valid),
        .age_addr  (age_addr),
        .age_data  (age_data),
        .look_addr (rd_addr),
        .look_hit  (look_hit),
        .look_data (look_data)
    );

    wb_rdctl #(.DW(DW)) u_rdctl (
        .clk       (clk),
        .rst_n     (rst_n),
        .fwd_mode  (fwd_mode),
        .rd_req    (rd_req),
        .buf_empty (empty),
        .look_hit  (look_hit),
        .look_data (look_data),
        .rd_ack    (rd_ack),
        .rd_hit    (rd_hit),
        .rd_data   (rd_data),
        .mem_rd_go (mem_rd_go),
        .hold_push (hold_push)
    );
endmodule

// File: rtl/wb_chk.sv
module wb_chk #(
    parameter int AW = 32,
    parameter int DW = 32
) (
    input logic          clk,
    input logic          rst_n,
    input logic          push_valid,
    input logic          push_ready,
    input logic          mem_wr_valid,
    input logic          mem_wr_ready,
    input logic [AW-1:0] mem_wr_addr,
    input logic [DW-1:0] mem_wr_data,
    input logic          rd_ack,
    input logic          rd_hit,
    input logic          mem_rd_go,
    input logic          full,
    input logic          empty
);
    // R3
    no_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        full |-> !push_ready);

    // R2
    head_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_wr_valid && !mem_wr_ready) |=>
            (mem_wr_valid && $stable(mem_wr_addr) && $stable(mem_wr_data)));

    // R4
    push_lands_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (push_valid && push_ready && !(mem_wr_valid && mem_wr_ready)) |=> !empty);

    // R10
    ack_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rd_ack |=> !rd_ack);

    // R10
    ans_gated_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_hit || mem_rd_go) |-> (rd_ack && (rd_hit != mem_rd_go)));
endmodule

bind write_buffer wb_chk #(.AW(AW), .DW(DW)) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .push_valid   (push_valid),
    .push_ready   (push_ready),
    .mem_wr_valid (mem_wr_valid),
    .mem_wr_ready (mem_wr_ready),
    .mem_wr_addr  (mem_wr_addr),
    .mem_wr_data  (mem_wr_data),
    .rd_ack       (rd_ack),
    .rd_hit       (rd_hit),
    .mem_rd_go    (mem_rd_go),
    .full         (full),
    .empty        (empty)
);

// File: tb/sim_write_buffer.sv
`timescale 1ns/1ps
module sim_write_buffer;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        fwd_mode = 1'b1;
    logic        push_valid = 1'b0;
    logic        push_ready;
    logic [31:0] push_addr = '0, push_data = '0;
    logic        mem_wr_valid;
    logic        mem_wr_ready = 1'b0;
    logic [31:0] mem_wr_addr, mem_wr_data;
    logic        rd_req = 1'b0;
    logic [31:0] rd_addr = '0;
    logic        rd_ack, rd_hit, mem_rd_go, full, empty;
    logic [31:0] rd_data;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #5 clk = ~clk;

    write_buffer u0 (.*);

    // {read address, expected hit, expected data}
    localparam logic [64:0] VEC [5] = '{
        {32'h0000_0010, 1'b1, 32'h0000_3333},
        {32'h0000_0020, 1'b1, 32'h0000_2222},
        {32'h0000_0030, 1'b1, 32'h0000_4444},
        {32'h0000_0040, 1'b0, 32'h0000_0000},
        {32'h0000_0000, 1'b0, 32'h0000_0000}
    };

    task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic push(input logic [31:0] a, input logic [31:0] d);
        push_valid = 1'b1; push_addr = a; push_data = d;
        while (!push_ready) @(negedge clk);
        @(negedge clk);
        push_valid = 1'b0;
    endtask

    task automatic drain(input string req, input logic [31:0] a, input logic [31:0] d);
        chk(req, {32'(mem_wr_valid), 32'h0}, {32'h1, 32'h0});
        chk(req, {mem_wr_addr, mem_wr_data}, {a, d});
        mem_wr_ready = 1'b1;
        @(negedge clk);
        mem_wr_ready = 1'b0;
    endtask

    task automatic lookup(input string req, input logic [31:0] a, input logic h, input logic [31:0] d);
        rd_req = 1'b1; rd_addr = a;
        @(negedge clk);
        rd_req = 1'b0;
        chk(req, {29'h0, rd_ack, rd_hit, mem_rd_go, rd_data}, {29'h0, 1'b1, h, !h, d});
        @(negedge clk);
        chk("R10", {61'h0, rd_ack, rd_hit, mem_rd_go}, 64'h0);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            checks++; errors++;
            $display("FAIL watchdog expired");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R1 reset state
        chk("R1", {59'h0, empty, full, mem_wr_valid, push_ready, rd_ack}, {59'h0, 5'b10010});

        // Move the pointers so later content wraps
        push(32'h70, 32'h7777); push(32'h71, 32'h7171);
        drain("R2", 32'h70, 32'h7777); drain("R2", 32'h71, 32'h7171);

        // Fill with drain stalled; two entries share address 0x10
        push(32'h10, 32'h1111); push(32'h20, 32'h2222);
        push(32'h10, 32'h3333); push(32'h30, 32'h4444);
        chk("R3", {62'h0, full, push_ready}, {62'h0, 2'b10});
        // R3: offer a store while full; it must not enter
        push_valid = 1'b1; push_addr = 32'h99; push_data = 32'h9999;
        @(negedge clk);
        chk("R3", {63'h0, push_ready}, 64'h0);
        push_valid = 1'b0;
        chk("R2", {mem_wr_addr, mem_wr_data}, {32'h10, 32'h1111});

        // Table walk: R5 hits, R6 newest wins for 0x10, R7 misses
        for (int i = 0; i < 5; i++) begin
            lookup(VEC[i][32] ? ((i == 0) ? "R6" : "R5") : "R7",
                   VEC[i][64:33], VEC[i][32], VEC[i][31:0]);
        end

        // R2 order and R3 refused store absent
        drain("R2", 32'h10, 32'h1111); drain("R2", 32'h20, 32'h2222);
        drain("R2", 32'h10, 32'h3333); drain("R3", 32'h30, 32'h4444);
        chk("R3", {63'h0, empty}, 64'h1);

        // R11: drained entry no longer matches
        push(32'h50, 32'h5555);
        drain("R11", 32'h50, 32'h5555);
        lookup("R11", 32'h50, 1'b0, 32'h0);

        // R4: push and drain in the same cycle
        push(32'h60, 32'h6060); push(32'h61, 32'h6161);
        push_valid = 1'b1; push_addr = 32'h62; push_data = 32'h6262;
        mem_wr_ready = 1'b1;
        @(negedge clk);
        push_valid = 1'b0; mem_wr_ready = 1'b0;
        drain("R4", 32'h61, 32'h6161);
        drain("R4", 32'h62, 32'h6262);
        chk("R4", {63'h0, empty}, 64'h1);

        // R8/R9: drain-first read with two entries, one matching
        fwd_mode = 1'b0;
        push(32'h80, 32'h8080); push(32'h81, 32'h8181);
        rd_req = 1'b1; rd_addr = 32'h80; mem_wr_ready = 1'b1;
        @(negedge clk);   // edge 1: to wait state, one entry drained
        rd_req = 1'b0;
        chk("R8", {63'h0, rd_ack}, 64'h0);
        chk("R9", {63'h0, push_ready}, 64'h0);
        @(negedge clk);   // edge 2: last entry drained
        chk("R8", {63'h0, rd_ack}, 64'h0);
        mem_wr_ready = 1'b0;
        @(negedge clk);   // edge 3: empty seen, answer
        chk("R8", {61'h0, rd_ack, rd_hit, mem_rd_go}, {61'h0, 3'b101});
        @(negedge clk);
        chk("R10", {62'h0, rd_ack, push_ready}, {62'h0, 2'b01});

        // R8: drain-first read on an empty buffer answers at once
        lookup("R8", 32'h80, 1'b0, 32'h0);

        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule